// File: doc/BRIEF.md
# Presettable up/down decade-binary counter

A four-bit synchronous counter that counts up or down on the rising clock edge, or holds its value. A static mode input selects the sequence: decade (0 to 9) or full binary (0 to 15). An active-low load input presets the counter from four data inputs at once, without waiting for a clock edge. The load takes priority over counting and over the enable.

Two outputs let several counters be chained. The terminal-count flag is combinational. It is high when the counter sits at the end of its sequence in the current direction. The active-low ripple-clock output pulses low during the low clock phase, but only when this stage is enabled and at terminal count. A following stage can use that pulse as its clock or as its carry/borrow enable.

Top module: `updn_ctr`

## Requirements
- R1: While `load_n_i` is low, `count_o` equals `data_i` with no clock edge needed. A change of `data_i` during that time appears on `count_o` at once.
- R2: A rising clock edge while `load_n_i` is low does no counting, even with the enable low. After release, the counter holds the data value present at the last rising edge or load assertion.
- R3: With load inactive and `en_n_i` high, the count does not change across rising clock edges.
- R4: With `en_n_i` low and `dir_i` = 0 (up), each rising edge adds one. In binary mode (`mode_bin_i` = 1) the count wraps from 15 to 0.
- R5: With `en_n_i` low and `dir_i` = 1 (down), each rising edge subtracts one. The count wraps from 0 to the mode maximum (15 in binary mode).
- R6: In decade mode (`mode_bin_i` = 0) the maximum is 9. Counting up wraps 9 to 0, and counting down wraps 0 to 9.
- R7: In decade mode, a loaded value of 10 to 15 goes to 0 on the next up count. On a down count it decreases by one per edge until it is back in range.
- R8: `tc_o` is high exactly when (`dir_i` = 0 and count = maximum) or (`dir_i` = 1 and count = 0). It follows the count, the mode and the direction without a clock edge, and `en_n_i` has no effect on it. It is therefore never high for decade values 10 to 15.
- R9: `rc_n_o` is low only while `en_n_i` is low, `tc_o` is high and `clk_i` is low. Otherwise it is high, including the whole high clock phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; counting on rising edge |
| load_n_i | input | 1 | Active-low asynchronous preset |
| data_i | input | 4 | Preset value |
| en_n_i | input | 1 | Active-low count enable |
| dir_i | input | 1 | 0 = count up, 1 = count down |
| mode_bin_i | input | 1 | 1 = binary 0..15, 0 = decade 0..9 (static) |
| count_o | output | 4 | Current count |
| tc_o | output | 1 | Terminal count flag |
| rc_n_o | output | 1 | Active-low ripple-clock pulse |

## Verification
A wrong next-state value shows on `count_o` just after the rising edge that registered it. From then on, every later value differs from an independent model, so one bad edge corrupts the rest of the sequence. A wrong maximum or direction decode also moves `tc_o`, and through it the `rc_n_o` pulse, within the same low clock phase. These are checked before the edge that would wrap. Load faults show within a nanosecond of asserting the load, or at the first edge after it is released.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_UP   = 2'd1,
        OP_DOWN = 2'd2
    } op_e;

endpackage

// File: rtl/ctr_next.sv
module ctr_next
    import ctr_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter int DEC_MAX = 9
) (
    input  logic [WIDTH-1:0] state_i,
    input  logic             en_n_i,
    input  logic             dir_i,
    input  logic             mode_bin_i,
    output logic [WIDTH-1:0] next_o
);

    localparam logic [WIDTH-1:0] BIN_MAX = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] DEC_TOP = WIDTH'(DEC_MAX);

    typedef struct packed {
        op_e             op;
        logic [WIDTH-1:0] state;
    } next_t;

    next_t            nxt_d;
    logic [WIDTH-1:0] top_val;
    logic             at_or_above;
    logic             at_zero;

    always_comb begin
        top_val     = mode_bin_i ? BIN_MAX : DEC_TOP;
        at_or_above = (state_i >= top_val);
        at_zero     = (state_i == '0);

        if (en_n_i)      nxt_d.op = OP_HOLD;
        else if (dir_i)  nxt_d.op = OP_DOWN;
        else             nxt_d.op = OP_UP;

        unique case (nxt_d.op)
            OP_UP:   nxt_d.state = at_or_above ? '0 : state_i + WIDTH'(1);
            OP_DOWN: nxt_d.state = at_zero ? top_val : state_i - WIDTH'(1);
            default: nxt_d.state = state_i;
        endcase
    end

    assign next_o = nxt_d.state;

endmodule

// File: rtl/ctr_term.sv
module ctr_term #(
    parameter int WIDTH   = 4,
    parameter int DEC_MAX = 9
) (
    input  logic             clk_i,
    input  logic [WIDTH-1:0] count_i,
    input  logic             en_n_i,
    input  logic             dir_i,
    input  logic             mode_bin_i,
    output logic             tc_o,
    output logic             rc_n_o
);

    localparam logic [WIDTH-1:0] BIN_MAX = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] DEC_TOP = WIDTH'(DEC_MAX);

    logic [WIDTH-1:0] top_val;
    logic             tc_d;

    always_comb begin
        top_val = mode_bin_i ? BIN_MAX : DEC_TOP;
        if (dir_i) tc_d = (count_i == '0);
        else       tc_d = (count_i == top_val);
    end

    assign tc_o   = tc_d;
    assign rc_n_o = ~(~en_n_i & tc_d & ~clk_i);

    // R9: while the clock is high the pulse is never low
    always_comb begin
        if (clk_i === 1'b1) begin
            AST_RC_HIGH_PHASE: assert (rc_n_o !== 1'b0); // R9
        end
    end

endmodule

// File: rtl/updn_ctr.sv
module updn_ctr #(
    parameter int WIDTH   = 4,
    parameter int DEC_MAX = 9
) (
    input  logic             clk_i,
    input  logic             load_n_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             en_n_i,
    input  logic             dir_i,
    input  logic             mode_bin_i,
    output logic [WIDTH-1:0] count_o,
    output logic             tc_o,
    output logic             rc_n_o
);

    localparam logic [WIDTH-1:0] BIN_MAX = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] DEC_TOP = WIDTH'(DEC_MAX);

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    logic [WIDTH-1:0] cur_max;

    ctr_next #(
        .WIDTH   (WIDTH),
        .DEC_MAX (DEC_MAX)
    ) u_next (
        .state_i    (state_q),
        .en_n_i     (en_n_i),
        .dir_i      (dir_i),
        .mode_bin_i (mode_bin_i),
        .next_o     (state_d)
    );

    always_ff @(posedge clk_i or negedge load_n_i) begin
        if (!load_n_i) state_q <= data_i;
        else           state_q <= state_d;
    end

    // preset is transparent while held low
    assign count_o = load_n_i ? state_q : data_i;

    ctr_term #(
        .WIDTH   (WIDTH),
        .DEC_MAX (DEC_MAX)
    ) u_term (
        .clk_i      (clk_i),
        .count_i    (count_o),
        .en_n_i     (en_n_i),
        .dir_i      (dir_i),
        .mode_bin_i (mode_bin_i),
        .tc_o       (tc_o),
        .rc_n_o     (rc_n_o)
    );

    assign cur_max = mode_bin_i ? BIN_MAX : DEC_TOP;

    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!load_n_i)
        en_n_i |=> $stable(count_o)); // R3
    AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!load_n_i)
        (!en_n_i && !dir_i && (count_o < cur_max)) |=> (count_o == $past(count_o) + WIDTH'(1))); // R4
    AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!load_n_i)
        (!en_n_i && !dir_i && tc_o) |=> (count_o == '0)); // R4
    AST_DOWN_WRAP: assert property (@(posedge clk_i) disable iff (!load_n_i)
        (!en_n_i && dir_i && tc_o) |=> (count_o == $past(cur_max))); // R5
    AST_ILLEGAL_UP: assert property (@(posedge clk_i) disable iff (!load_n_i)
        (!en_n_i && !dir_i && !mode_bin_i && (count_o > DEC_TOP)) |=> (count_o == '0)); // R7
    AST_TC_ENDS: assert property (@(posedge clk_i) disable iff (!load_n_i)
        tc_o |-> ((count_o == '0) || (count_o == cur_max))); // R8

endmodule

// File: tb/updn_ctr_bench.sv
module updn_ctr_bench;

    logic       clk = 1'b0;
    logic       load_n;
    logic [3:0] data;
    logic       en_n;
    logic       dir;
    logic       mode_bin;
    logic [3:0] count;
    logic       tc;
    logic       rc_n;

    int n_total = 0;
    int n_err   = 0;
    int mstate  = 0;
    int mmode   = 1;

    typedef struct {
        int    cnt;
        int    tcv;
        string tag;
    } exp_t;
    exp_t sb[$];

    updn_ctr u_updn_ctr (
        .clk_i      (clk),
        .load_n_i   (load_n),
        .data_i     (data),
        .en_n_i     (en_n),
        .dir_i      (dir),
        .mode_bin_i (mode_bin),
        .count_o    (count),
        .tc_o       (tc),
        .rc_n_o     (rc_n)
    );

    always #4 clk = ~clk;

    function automatic int maxf(int bin);
        return bin ? 15 : 9;
    endfunction

    function automatic int tcf(int s, int d, int bin);
        return d ? int'(s == 0) : int'(s == maxf(bin));
    endfunction

    function automatic int nextf(int s, int d, int bin);
        if (d == 0) return (s >= maxf(bin)) ? 0 : s + 1;
        return (s == 0) ? maxf(bin) : s - 1;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_total++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // driver: one clock cycle, checks low phase, pushes expected post-edge value
    task automatic step(int en, int d, string tag);
        int tce;
        @(negedge clk);
        en_n = en[0];
        dir  = d[0];
        #1;
        tce = tcf(mstate, d, mmode);
        chk(tag, "tc low phase (R8)", int'(tc), tce);
        chk(tag, "rc_n low phase (R9)", int'(rc_n), (en == 0 && tce == 1) ? 0 : 1);
        if (en == 0) mstate = nextf(mstate, d, mmode);
        sb.push_back('{mstate, tcf(mstate, d, mmode), tag});
    endtask

    task automatic run(int n, int en, int d, string tag);
        for (int i = 0; i < n; i++) step(en, d, tag);
    endtask

    // preset spanning one rising edge with counting enabled (R1, R2)
    task automatic preset(int bin, int v1, int v2, string tag);
        @(negedge clk);
        mode_bin = bin[0];
        mmode    = bin;
        load_n   = 1'b0;
        en_n     = 1'b0;
        data     = 4'(v1);
        #1;
        chk(tag, "R1 count follows data", int'(count), v1);
        data = 4'(v2);
        #1;
        chk(tag, "R1 count follows new data", int'(count), v2);
        chk(tag, "R8 tc on preset value", int'(tc), tcf(v2, int'(dir), bin));
        sb.push_back('{v2, tcf(v2, int'(dir), bin), "R2 edge during load"});
        @(negedge clk);
        load_n = 1'b1;
        en_n   = 1'b1;
        #1;
        chk(tag, "R2 value after release", int'(count), v2);
        mstate = v2;
    endtask

    // monitor: pops after every rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            chk("R9", "rc_n high phase", int'(rc_n), 1);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk(e.tag, "count", int'(count), e.cnt);
                chk(e.tag, "tc", int'(tc), e.tcv);
            end
        end
    end

    initial begin
        #800000;
        n_total++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_err);
        $finish;
    end

    initial begin
        load_n   = 1'b0;
        data     = 4'd0;
        en_n     = 1'b1;
        dir      = 1'b0;
        mode_bin = 1'b1;
        #2;
        chk("R1", "initial preset", int'(count), 0);
        @(negedge clk);
        load_n = 1'b1;
        mstate = 0;

        run(18, 0, 0, "R4");
        run(3, 1, 0, "R3");
        run(20, 0, 1, "R5");
        preset(1, 3, 13, "R2");
        run(4, 0, 0, "R4");
        step(1, 1, "R8");
        step(1, 0, "R8");

        preset(0, 2, 7, "R6");
        run(5, 0, 0, "R6");
        run(12, 0, 1, "R6");
        run(2, 1, 1, "R3");
        step(0, 0, "R6");
        step(0, 1, "R6");
        step(1, 0, "R8");

        preset(0, 9, 12, "R7");
        run(2, 0, 0, "R7");
        preset(0, 1, 14, "R7");
        run(7, 0, 1, "R7");
        preset(0, 5, 10, "R7");
        step(1, 1, "R8");
        step(0, 1, "R7");
        run(3, 0, 0, "R7");

        preset(1, 0, 15, "R5");
        run(3, 0, 0, "R4");
        run(3, 0, 1, "R5");

        @(posedge clk);
        #2;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_err);
        $finish;
    end

endmodule